// File: doc/BRIEF.md
# Cumulative-Sum Frame Offset Detector

The block finds where a fresh symbol frame begins inside a window of received baseband samples. After a start command it takes the next 100 valid samples. It multiplies each sample by the local cosine reference and by the local sine reference, both supplied at the same instant as the sample. It keeps a running prefix sum of each product stream, so it builds two candidate sequences. The candidate with the larger spread is kept. That spread is judged by the scaled variance N·Σb² − (Σb)², which needs no division.

The kept sequence is smoothed by a 4-point running average. Each smoothed value is compared against the first smoothed value. The positions of the largest and the smallest difference are tracked. Of these two positions, the one closer to either edge of the window is reported as the frame offset. A one-cycle done pulse marks the result. The offset then stays put until the next result replaces it.

A receiver uses the offset to discard the leading samples of a damaged frame before demodulation.

Top module: `fod_offset_detector`

## Requirements
- R1: After reset, done is 0 and offset is 0.
- R2: A start seen while the block is idle arms a capture. The 100 following clock edges with sample_valid high each take one sample together with its two references. Edges with sample_valid low take nothing. Sample and references are signed two's complement.
- R3: A start seen while a capture or a computation is under way has no effect on the window in progress or on its result.
- R4: For each captured index k the block forms the cosine candidate bc_k = Σ_{j≤k} x_j·cos_j and the sine candidate bs_k = Σ_{j≤k} x_j·sin_j. It computes the scaled variance V = 100·Σb² − (Σb)² of each candidate. The sine candidate is kept only when its V is strictly larger; on a tie the cosine candidate is kept.
- R5: The kept sequence b_1..b_100 is smoothed as f_k = floor((b_k + b_{k−1} + b_{k−2} + b_{k−3}) / 4). Any b index below 1 is replaced by b_1.
- R6: The difference array is O_j = f_{j+1} − f_1 for j = 1..99. The maximum position is the first j holding the largest O value, and the minimum position is the first j holding the smallest.
- R7: With edge distance e(p) = min(p, 100 − p), the offset is the maximum position when its edge distance is strictly smaller than that of the minimum position. Otherwise the offset is the minimum position.
- R8: done is high for exactly one cycle, 102 clock edges after the edge that takes the 100th sample. The offset changes only at that edge and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new window capture when idle |
| sample_valid | input | 1 | Sample and references are valid this cycle |
| sample | input | 8 | Received sample, signed |
| cos_ref | input | 8 | Local cosine reference, signed |
| sin_ref | input | 8 | Local sine reference, signed |
| offset | output | 7 | Detected frame offset, 1..99 |
| done | output | 1 | One-cycle pulse when a new offset is presented |

## Verification
The result appears 102 clock edges after the edge that takes the 100th valid sample. That edge is counted on the design's own input timing, so gaps in sample_valid only delay it. The bench reference model counts these edges behaviourally. It predicts the level of done and the value of offset for every cycle, and compares both at each falling edge. A misplaced pulse or an early or late change of offset is therefore seen in the very cycle it happens. The offset value itself is computed from the captured samples with plain integer arithmetic, and it is checked in the cycle that done is predicted.

// File: rtl/fod_pkg.sv
package fod_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CAPT = 3'd1,
        ST_CMP  = 3'd2,
        ST_SCAN = 3'd3,
        ST_FIN  = 3'd4
    } fod_state_e;

endpackage

// File: rtl/fod_capture.sv
module fod_capture #(
    parameter int N   = 100,
    parameter int SW  = 8,
    parameter int RW  = 8,
    parameter int IW  = 7,
    parameter int AW  = 24,
    parameter int S1W = 32,
    parameter int S2W = 56
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic signed [SW-1:0]  sample,
    input  logic signed [RW-1:0]  cos_ref,
    input  logic signed [RW-1:0]  sin_ref,
    input  logic                  rd_sel,
    input  logic [IW-1:0]         rd_idx,
    output logic signed [AW-1:0]  rd_data,
    output logic signed [S1W-1:0] sum1 [2],
    output logic signed [S2W-1:0] sum2 [2]
);

    localparam int PW = SW + RW;

    logic signed [AW-1:0] rd_val [2];

    for (genvar g = 0; g < 2; g++) begin : g_chan
        typedef struct packed {
            logic signed [AW-1:0]  run;
            logic signed [S1W-1:0] s1;
            logic signed [S2W-1:0] s2;
        } chan_s;

        chan_s                 ch_d, ch_q;
        logic signed [RW-1:0]  ref_v;
        logic signed [PW-1:0]  prod;
        logic signed [AW-1:0]  b_new;
        logic signed [S2W-1:0] b_sq;
        logic signed [AW-1:0]  mem [N];

        assign ref_v = (g == 0) ? cos_ref : sin_ref;
        assign prod  = PW'(sample) * PW'(ref_v);
        assign b_new = ch_q.run + AW'(prod);
        assign b_sq  = S2W'(b_new) * S2W'(b_new);

        always_comb begin
            ch_d = ch_q;
            if (clear) begin
                ch_d = '0;
            end else if (wr_en) begin
                ch_d.run = b_new;
                ch_d.s1  = ch_q.s1 + S1W'(b_new);
                ch_d.s2  = ch_q.s2 + b_sq;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q <= '0;
            else        ch_q <= ch_d;
        end

        always_ff @(posedge clk) begin
            if (wr_en && !clear) mem[wr_idx] <= b_new;
        end

        assign rd_val[g] = mem[rd_idx];
        assign sum1[g]   = ch_q.s1;
        assign sum2[g]   = ch_q.s2;
    end

    assign rd_data = rd_sel ? rd_val[1] : rd_val[0];

endmodule

// File: rtl/fod_var_cmp.sv
module fod_var_cmp #(
    parameter int N   = 100,
    parameter int S1W = 32,
    parameter int S2W = 56,
    parameter int VW  = 65
) (
    input  logic signed [S1W-1:0] sum1 [2],
    input  logic signed [S2W-1:0] sum2 [2],
    output logic                  pick_sin
);

    localparam logic signed [VW-1:0] NV = VW'(N);

    logic signed [VW-1:0] var_s [2];

    for (genvar g = 0; g < 2; g++) begin : g_var
        logic signed [VW-1:0] s1x;
        assign s1x      = VW'(sum1[g]);
        assign var_s[g] = NV * VW'(sum2[g]) - s1x * s1x;
    end

    always_comb begin
        pick_sin = (var_s[1] > var_s[0]);
    end

endmodule

// File: rtl/fod_tracker.sv
module fod_tracker #(
    parameter int AW = 24,
    parameter int IW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 first,
    input  logic [IW-1:0]        idx,
    input  logic signed [AW-1:0] value,
    output logic [IW-1:0]        pos_max,
    output logic [IW-1:0]        pos_min
);

    localparam int SUMW = AW + 2;
    localparam int DW   = AW + 1;

    typedef struct packed {
        logic signed [AW-1:0] h1;
        logic signed [AW-1:0] h2;
        logic signed [AW-1:0] h3;
        logic signed [AW-1:0] f1;
        logic signed [DW-1:0] maxv;
        logic signed [DW-1:0] minv;
        logic [IW-1:0]        pmax;
        logic [IW-1:0]        pmin;
    } trk_s;

    trk_s                   tr_d, tr_q;
    logic signed [SUMW-1:0] win_sum;
    logic signed [AW-1:0]   f_cur;
    logic signed [DW-1:0]   diff;

    assign win_sum = SUMW'(value) + SUMW'(tr_q.h1) + SUMW'(tr_q.h2) + SUMW'(tr_q.h3);
    assign f_cur   = AW'(win_sum >>> 2);
    assign diff    = DW'(f_cur) - DW'(tr_q.f1);

    always_comb begin
        tr_d = tr_q;
        if (en) begin
            if (first) begin
                tr_d.h1 = value;
                tr_d.h2 = value;
                tr_d.h3 = value;
                tr_d.f1 = value;
            end else begin
                tr_d.h1 = value;
                tr_d.h2 = tr_q.h1;
                tr_d.h3 = tr_q.h2;
                if (idx == IW'(1)) begin
                    tr_d.maxv = diff;
                    tr_d.minv = diff;
                    tr_d.pmax = idx;
                    tr_d.pmin = idx;
                end else begin
                    if (diff > tr_q.maxv) begin
                        tr_d.maxv = diff;
                        tr_d.pmax = idx;
                    end
                    if (diff < tr_q.minv) begin
                        tr_d.minv = diff;
                        tr_d.pmin = idx;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    assign pos_max = tr_q.pmax;
    assign pos_min = tr_q.pmin;

endmodule

// File: rtl/fod_offset_detector.sv
module fod_offset_detector
    import fod_pkg::*;
#(
    parameter int N  = 100,
    parameter int SW = 8,
    parameter int RW = 8,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 sample_valid,
    input  logic signed [SW-1:0] sample,
    input  logic signed [RW-1:0] cos_ref,
    input  logic signed [RW-1:0] sin_ref,
    output logic [IW-1:0]        offset,
    output logic                 done
);

    localparam int LW  = $clog2(N) + 1;
    localparam int AW  = SW + RW + LW;
    localparam int S1W = AW + LW;
    localparam int S2W = 2 * AW + LW;
    localparam int VW  = S2W + LW + 2;
    localparam logic [IW:0] NW = (IW+1)'(N);

    typedef struct packed {
        fod_state_e    state;
        logic [IW-1:0] cnt;
        logic          sel;
        logic [IW-1:0] offset;
        logic          done;
    } top_s;

    top_s                  st_d, st_q;
    fod_state_e            state_q;
    logic [IW-1:0]         cnt_q;
    logic                  cap_clear, cap_wr;
    logic signed [AW-1:0]  rd_data;
    logic signed [S1W-1:0] sum1 [2];
    logic signed [S2W-1:0] sum2 [2];
    logic                  pick_sin;
    logic                  trk_en, trk_first;
    logic [IW-1:0]         pos_max, pos_min;
    logic [IW:0]           pmax_x, pmin_x, dist_max, dist_min;

    fod_capture #(
        .N(N), .SW(SW), .RW(RW), .IW(IW), .AW(AW), .S1W(S1W), .S2W(S2W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cap_clear),
        .wr_en   (cap_wr),
        .wr_idx  (st_q.cnt),
        .sample  (sample),
        .cos_ref (cos_ref),
        .sin_ref (sin_ref),
        .rd_sel  (st_q.sel),
        .rd_idx  (st_q.cnt),
        .rd_data (rd_data),
        .sum1    (sum1),
        .sum2    (sum2)
    );

    fod_var_cmp #(
        .N(N), .S1W(S1W), .S2W(S2W), .VW(VW)
    ) u_var_cmp (
        .sum1     (sum1),
        .sum2     (sum2),
        .pick_sin (pick_sin)
    );

    fod_tracker #(
        .AW(AW), .IW(IW)
    ) u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (trk_en),
        .first   (trk_first),
        .idx     (st_q.cnt),
        .value   (rd_data),
        .pos_max (pos_max),
        .pos_min (pos_min)
    );

    assign pmax_x   = {1'b0, pos_max};
    assign pmin_x   = {1'b0, pos_min};
    assign dist_max = (pmax_x < NW - pmax_x) ? pmax_x : NW - pmax_x;
    assign dist_min = (pmin_x < NW - pmin_x) ? pmin_x : NW - pmin_x;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cap_clear = 1'b0;
        cap_wr    = 1'b0;
        trk_en    = 1'b0;
        trk_first = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    cap_clear  = 1'b1;
                    st_d.cnt   = '0;
                    st_d.state = ST_CAPT;
                end
            end
            ST_CAPT: begin
                if (sample_valid) begin
                    cap_wr = 1'b1;
                    if (st_q.cnt == IW'(N - 1)) begin
                        st_d.cnt   = '0;
                        st_d.state = ST_CMP;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            ST_CMP: begin
                st_d.sel   = pick_sin;
                st_d.cnt   = '0;
                st_d.state = ST_SCAN;
            end
            ST_SCAN: begin
                trk_en    = 1'b1;
                trk_first = (st_q.cnt == '0);
                if (st_q.cnt == IW'(N - 1)) begin
                    st_d.state = ST_FIN;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            ST_FIN: begin
                st_d.offset = (dist_max < dist_min) ? pos_max : pos_min;
                st_d.done   = 1'b1;
                st_d.state  = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: ST_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign state_q = st_q.state;
    assign cnt_q   = st_q.cnt;
    assign offset  = st_q.offset;
    assign done    = st_q.done;

endmodule

// File: rtl/fod_chk.sv
module fod_chk
    import fod_pkg::*;
#(
    parameter int N  = 100,
    parameter int IW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_valid,
    input logic          done,
    input logic [IW-1:0] offset,
    input fod_state_e    state_q,
    input logic [IW-1:0] cnt_q
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(offset));

    // R7
    offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (offset >= IW'(1) && offset <= IW'(N - 1)));

    // R2
    gap_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPT && !sample_valid) |=> $stable(cnt_q));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state_q == ST_IDLE);

endmodule

bind fod_offset_detector fod_chk #(.N(N), .IW(IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .done         (done),
    .offset       (offset),
    .state_q      (state_q),
    .cnt_q        (cnt_q)
);

// File: tb/tb_fod_offset_detector.sv
`timescale 1ns/1ps
module tb_fod_offset_detector;

    localparam int N = 100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              sample_valid = 1'b0;
    logic signed [7:0] sample = '0;
    logic signed [7:0] cos_ref = '0;
    logic signed [7:0] sin_ref = '0;
    logic [6:0]        offset;
    logic              done;

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R7";

    fod_offset_detector dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
        .sample(sample), .cos_ref(cos_ref), .sin_ref(sin_ref),
        .offset(offset), .done(done)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    int     m_armed = 0, m_cnt = 0, m_cd = 0;
    longint xs[N], cs[N], ss[N];
    bit     exp_done = 0;
    int     exp_off = 0;

    function automatic int edist(int p);
        return (p < N - p) ? p : N - p;
    endfunction

    function automatic int model_offset();
        longint bc[N], bs[N], b[N], f[N];
        longint rc = 0, rs = 0, s1c = 0, s2c = 0, s1s = 0, s2s = 0, vc, vs, o, mx, mn;
        int pmx = 1, pmn = 1;
        for (int k = 0; k < N; k++) begin
            rc += xs[k] * cs[k];
            rs += xs[k] * ss[k];
            bc[k] = rc; bs[k] = rs;
            s1c += rc; s2c += rc * rc;
            s1s += rs; s2s += rs * rs;
        end
        vc = N * s2c - s1c * s1c;
        vs = N * s2s - s1s * s1s;
        for (int k = 0; k < N; k++) b[k] = (vs > vc) ? bs[k] : bc[k];
        for (int k = 0; k < N; k++)
            f[k] = (b[k] + b[(k >= 1) ? k - 1 : 0] + b[(k >= 2) ? k - 2 : 0]
                    + b[(k >= 3) ? k - 3 : 0]) >>> 2;
        mx = f[1] - f[0]; mn = mx;
        for (int j = 2; j < N; j++) begin
            o = f[j] - f[0];
            if (o > mx) begin mx = o; pmx = j; end
            if (o < mn) begin mn = o; pmn = j; end
        end
        return (edist(pmx) < edist(pmn)) ? pmx : pmn;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_armed = 0; m_cnt = 0; m_cd = 0; exp_done = 0; exp_off = 0;
        end else begin
            exp_done = 0;
            if (m_cd > 0) begin
                m_cd--;
                if (m_cd == 0) begin
                    exp_done = 1;
                    exp_off  = model_offset();
                end
            end else if (m_armed != 0) begin
                if (sample_valid) begin
                    xs[m_cnt] = sample; cs[m_cnt] = cos_ref; ss[m_cnt] = sin_ref;
                    m_cnt++;
                    if (m_cnt == N) begin
                        m_armed = 0;
                        m_cd    = 102;
                    end
                end
            end else if (start) begin
                m_armed = 1;
                m_cnt   = 0;
            end
        end
    end

    task automatic check(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(done == exp_done, "R8 done timing", int'(done), int'(exp_done));
            check(int'(offset) == exp_off, exp_done ? cur_tag : "R8 offset hold",
                  int'(offset), exp_off);
        end
    end

    function automatic int trig(int k);
        case (k % 8)
            0: return 100;
            1: return 71;
            2: return 0;
            3: return -71;
            4: return -100;
            5: return -71;
            6: return 0;
            default: return 71;
        endcase
    endfunction

    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [15:0] lfsr_next(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // mode 0 random, 1 sine only, 2 zeros, 3 random with gaps and stray starts, 4 step
    task automatic run_window(int mode);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (mode == 3) begin
                sample_valid = 1'b0;
                sample       = 8'sd55;
                start        = (k % 7 == 3);
                @(negedge clk);
                start = 1'b0;
            end
            lfsr         = lfsr_next(lfsr);
            sample_valid = 1'b1;
            case (mode)
                2:       sample = '0;
                4:       sample = (k < 37) ? 8'sd90 : -8'sd90;
                default: sample = lfsr[7:0];
            endcase
            cos_ref = (mode == 1) ? 8'sd0 : 8'(trig(k));
            sin_ref = 8'(trig(k + 6));
            @(negedge clk);
        end
        sample_valid = 1'b0;
        start        = (mode == 3);
        @(negedge clk);
        start = 1'b0;
        repeat (110) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        check(offset == 7'd0, "R1 reset offset", int'(offset), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "R5 R6 R7 random window";
        run_window(0);
        cur_tag = "R4 sine candidate kept";
        run_window(1);
        cur_tag = "R4 R7 zero window tie";
        run_window(2);
        check(int'(offset) == 1, "R4 R7 all-zero offset", int'(offset), 1);
        cur_tag = "R2 R3 gaps and stray starts";
        run_window(3);
        cur_tag = "R6 R7 step window";
        run_window(4);
        cur_tag = "R5 R6 random window two";
        run_window(0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule